// File: doc/BRIEF.md
# Set/Reset Compare Waveform Generator

This block generates up to four pulse waveforms from one shared 16-bit up-counting timer. The eight compare channels are grouped into pairs. In each pair, the even channel holds the set value and the odd channel holds the clear value. When the timer reaches the set value, the pair's output state goes active. When the timer reaches the clear value, the state goes inactive. Every match on an active pair also raises a one-clock interrupt pulse for that channel.

The timer advances on each clock where the timer clock enable is high. Its period is chosen by a two-bit select:
- In free-running mode the timer wraps through all 65536 values.
- In the two cleared modes the timer returns to zero when it matches either the set value of pair 0 or a dedicated period register. After a clear, the timer rests at zero for one extra tick, so the period is p + 2 ticks.
- When pair 0's set value is the clear source, pair 0 cannot produce a waveform.

Each pair has its own controls:
- an initial level, held while the pair is not running;
- an invert control;
- an output enable that hands the pin to a general-purpose level.

When the output enable is set again, the pin shows the pair's current set/reset state. The waveform does not restart.

Top module: `srwave_gen`

## Requirements
- R1: In free-running mode (`rst_sel` = 2'b00 or 2'b11) the timer rises by one on each clock with `tick_en` high, keeps its value on each clock with `tick_en` low, and wraps from FFFFh to 0000h with no extra cycle.
- R2: With `rst_sel` = 2'b10, a tick on which the timer equals `period_val` loads 0000h. The next tick keeps 0000h, and the tick after that gives 0001h, so the timer repeats every `period_val` + 2 ticks.
- R3: With `rst_sel` = 2'b01, the timer is cleared in the same way on a match with channel 0's compare value. Pair 0 then produces no interrupts (`match_irq[1:0]` stays 0) and holds its initial level.
- R4: For pair i, a tick where the timer equals channel 2i's value drives the state high. A tick where it equals channel 2i+1's value drives it low, and clear wins if both match. `wave_out[i]` changes on the clock edge that ends that tick, so with set value m less than clear value n the state is high for n − m ticks per period.
- R5: `match_irq[c]` is a single-clock pulse. It is asserted after the tick on which the timer equals channel c's value, and only while that channel's pair is running.
- R6: A pair runs only while both of its channel enables (`ch_en[2i]` and `ch_en[2i+1]`) are high. While a pair is stopped, its state is loaded from `pair_init[i]` each clock and it raises no interrupts.
- R7: With `pair_oe[i]` high, `wave_out[i]` equals the pair state XOR `pair_inv[i]`.
- R8: With `pair_oe[i]` low, `wave_out[i]` follows `gpo_val[i]` and the set/reset state keeps evolving. Raising `pair_oe[i]` again shows the held state at once, without restarting the waveform.
- R9: During reset the timer reads 0000h, every interrupt is low and every pair state is 0.
- R10: The extra zero tick that follows a clear raises no second match, so a compare value of 0000h gives exactly one interrupt per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timer clock enable; one timer tick per clock where high |
| rst_sel | input | 2 | Period source: 00/11 free-running, 01 channel 0 compare, 10 period register |
| period_val | input | 16 | Period register value p |
| cmp_val | input | 128 | Eight 16-bit compare values; channel c occupies bits [16c+15:16c] |
| ch_en | input | 8 | Per-channel enable |
| pair_init | input | 4 | Per-pair initial state level |
| pair_inv | input | 4 | Per-pair output inversion |
| pair_oe | input | 4 | Per-pair output enable (0 selects the general-purpose level) |
| gpo_val | input | 4 | General-purpose level driven when the pair output is disabled |
| timer_val | output | 16 | Current base timer value |
| match_irq | output | 8 | Per-channel match interrupt pulse |
| wave_out | output | 4 | Per-pair waveform output |

## Verification
The assertions check the following on every clock:
- the timer step and hold in free-running mode;
- the load of zero and the following rest tick after a period-register match;
- the silence of pair 0 while channel 0 clears the timer;
- that each interrupt is preceded by a live tick;
- that a running, enabled, non-inverting-change output moves only together with one of its pair's interrupts.

Only the directed scenarios can show the following:
- the full period lengths (p + 2 and the 65536-value wrap);
- the active width n − m;
- the single interrupt at value zero across the rest tick;
- the held initial level of a stopped pair;
- the inversion;
- the resumption of the waveform after the output enable returns.

// File: rtl/srwave_pkg.sv
`timescale 1ns/1ps
package srwave_pkg;

  // Period source selection for the base timer
  typedef enum logic [1:0] {
    RST_FREE     = 2'b00,
    RST_CMP0     = 2'b01,
    RST_PERIOD   = 2'b10,
    RST_FREE_ALT = 2'b11
  } rst_mode_e;

  // Pair 0 is barred from waveform output when its set value clears the timer
  function automatic logic pair_blocked(input rst_mode_e mode, input int pair_idx);
    return (mode == RST_CMP0) && (pair_idx == 0);
  endfunction

endpackage

// File: rtl/srwave_timebase.sv
`timescale 1ns/1ps
module srwave_timebase
  import srwave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  rst_mode_e        mode,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             hold,
  output logic             cnt_live
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             clr_hit;

  // Clear condition for the selected period source
  always_comb begin
    unique case (mode)
      RST_CMP0:   clr_hit = (cnt_q == cmp0);
      RST_PERIOD: clr_hit = (cnt_q == period);
      default:    clr_hit = 1'b0;
    endcase
  end

  // Next state: a clear loads zero and arms one rest tick at zero
  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (tick_en) begin
      if (hold_q) begin
        hold_d = 1'b0;
      end else if (clr_hit) begin
        cnt_d  = '0;
        hold_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign cnt      = cnt_q;
  assign hold     = hold_q;
  assign cnt_live = tick_en & ~hold_q;

endmodule

// File: rtl/srwave_pair.sv
`timescale 1ns/1ps
module srwave_pair #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_live,
  input  logic [CNT_W-1:0] set_val,
  input  logic [CNT_W-1:0] clr_val,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic             blocked,
  input  logic             init_lvl,
  input  logic             inv,
  input  logic             oe,
  input  logic             gpo,
  output logic             active,
  output logic [1:0]       irq,
  output logic             wave
);

  logic       state_q, state_d;
  logic [1:0] irq_q, irq_d;
  logic       hit_set, hit_clr;

  assign active  = set_en & clr_en & ~blocked;
  assign hit_set = active & cnt_live & (cnt == set_val);
  assign hit_clr = active & cnt_live & (cnt == clr_val);

  // Set/reset state: clear has priority; a stopped pair tracks its initial level
  always_comb begin
    state_d = state_q;
    if (!active) begin
      state_d = init_lvl;
    end else if (hit_clr) begin
      state_d = 1'b0;
    end else if (hit_set) begin
      state_d = 1'b1;
    end
    irq_d = {hit_clr, hit_set};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      irq_q   <= '0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign irq  = irq_q;
  assign wave = oe ? (state_q ^ inv) : gpo;

endmodule

// File: rtl/srwave_gen.sv
`timescale 1ns/1ps
module srwave_gen
  import srwave_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_PAIRS = 4,
  localparam int NUM_CH   = 2 * NUM_PAIRS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_en,
  input  logic [1:0]              rst_sel,
  input  logic [CNT_W-1:0]        period_val,
  input  logic [NUM_CH*CNT_W-1:0] cmp_val,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_PAIRS-1:0]    pair_init,
  input  logic [NUM_PAIRS-1:0]    pair_inv,
  input  logic [NUM_PAIRS-1:0]    pair_oe,
  input  logic [NUM_PAIRS-1:0]    gpo_val,
  output logic [CNT_W-1:0]        timer_val,
  output logic [NUM_CH-1:0]       match_irq,
  output logic [NUM_PAIRS-1:0]    wave_out
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rsync_q[1];

  rst_mode_e              mode;
  logic [CNT_W-1:0]       cnt;
  logic                   hold;
  logic                   cnt_live;
  logic [NUM_PAIRS-1:0]   pair_act;

  assign mode = rst_mode_e'(rst_sel);

  srwave_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_en  (tick_en),
    .mode     (mode),
    .cmp0     (cmp_val[CNT_W-1:0]),
    .period   (period_val),
    .cnt      (cnt),
    .hold     (hold),
    .cnt_live (cnt_live)
  );

  for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
    srwave_pair #(.CNT_W(CNT_W)) i_pair (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cnt      (cnt),
      .cnt_live (cnt_live),
      .set_val  (cmp_val[(2*gi)*CNT_W +: CNT_W]),
      .clr_val  (cmp_val[(2*gi+1)*CNT_W +: CNT_W]),
      .set_en   (ch_en[2*gi]),
      .clr_en   (ch_en[2*gi+1]),
      .blocked  (pair_blocked(mode, gi)),
      .init_lvl (pair_init[gi]),
      .inv      (pair_inv[gi]),
      .oe       (pair_oe[gi]),
      .gpo      (gpo_val[gi]),
      .active   (pair_act[gi]),
      .irq      (match_irq[2*gi +: 2]),
      .wave     (wave_out[gi])
    );
  end

  assign timer_val = cnt;

endmodule

// File: rtl/srwave_chk.sv
`timescale 1ns/1ps
module srwave_chk #(
  parameter int CNT_W     = 16,
  parameter int NUM_PAIRS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_en,
  input logic [1:0]             rst_sel,
  input logic [CNT_W-1:0]       period_val,
  input logic [CNT_W-1:0]       timer_val,
  input logic                   hold,
  input logic [NUM_PAIRS-1:0]   pair_act,
  input logic [NUM_PAIRS-1:0]   pair_oe,
  input logic [NUM_PAIRS-1:0]   pair_inv,
  input logic [2*NUM_PAIRS-1:0] match_irq,
  input logic [NUM_PAIRS-1:0]   wave_out
);

  assert_free_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !hold && (rst_sel == 2'b00)) |=> (timer_val == CNT_W'($past(timer_val) + 1'b1)));

  assert_idle_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(timer_val));

  assert_period_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_sel == 2'b10) && tick_en && !hold && (timer_val == period_val))
      |=> ((timer_val == '0) && hold));

  assert_pair0_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sel == 2'b01) |=> (match_irq[1:0] == 2'b00));

  assert_irq_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq != '0) |-> $past(tick_en && !hold));

  for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_chk
    assert_wave_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pair_act[gi]) && pair_oe[gi] && $past(pair_oe[gi]) &&
       $stable(pair_inv[gi]) && !$stable(wave_out[gi]))
        |-> (match_irq[2*gi] || match_irq[2*gi+1]));
  end

endmodule

bind srwave_gen srwave_chk #(.CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS)) i_srwave_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick_en    (tick_en),
  .rst_sel    (rst_sel),
  .period_val (period_val),
  .timer_val  (timer_val),
  .hold       (hold),
  .pair_act   (pair_act),
  .pair_oe    (pair_oe),
  .pair_inv   (pair_inv),
  .match_irq  (match_irq),
  .wave_out   (wave_out)
);

// File: tb/test_srwave_gen.sv
`timescale 1ns/1ps
module test_srwave_gen;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick_en;
  logic [1:0]   rst_sel;
  logic [15:0]  period_val;
  logic [127:0] cmp_val;
  logic [7:0]   ch_en;
  logic [3:0]   pair_init, pair_inv, pair_oe, gpo_val;
  logic [15:0]  timer_val;
  logic [7:0]   match_irq;
  logic [3:0]   wave_out;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  srwave_gen i_srwave_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rst_sel(rst_sel),
    .period_val(period_val), .cmp_val(cmp_val), .ch_en(ch_en),
    .pair_init(pair_init), .pair_inv(pair_inv), .pair_oe(pair_oe),
    .gpo_val(gpo_val), .timer_val(timer_val), .match_irq(match_irq),
    .wave_out(wave_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_timer(input logic [15:0] v);
    int guard = 0;
    while (timer_val != v && guard < 70000) begin
      tick();
      guard++;
    end
    check("setup", "timer reached target", int'(timer_val == v), 1);
  endtask

  task automatic set_cmp(input int ch, input logic [15:0] v);
    cmp_val[ch*16 +: 16] = v;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    tick_en = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic defaults();
    rst_sel = 2'b10; period_val = 16'd20; cmp_val = '0;
    set_cmp(0, 16'd0); set_cmp(1, 16'd3); set_cmp(2, 16'd5); set_cmp(3, 16'd9);
    ch_en = 8'h00; pair_init = '0; pair_inv = '0; pair_oe = 4'hF; gpo_val = '0;
  endtask

  // R9: reset state
  task automatic test_reset();
    defaults();
    rst_n = 1'b0; tick_en = 1'b0;
    repeat (3) tick();
    check("R9", "timer in reset", timer_val, 0);
    check("R9", "irq in reset", match_irq, 0);
    check("R9", "wave in reset", wave_out, 0);
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  // R2, R4, R5, R10: period register mode, pair 0 and pair 1 running
  task automatic test_period();
    int n, i0, i1, i2, i3, w0, w1;
    defaults(); ch_en = 8'h0F;
    apply_reset();
    tick_en = 1'b1;
    wait_timer(16'd5);
    check("R4", "pair1 low before set", wave_out[1], 0);
    tick();
    check("R4", "pair1 high after set tick", wave_out[1], 1);
    check("R5", "irq ch2 pulse", match_irq[2], 1);
    tick();
    check("R5", "irq ch2 single cycle", match_irq[2], 0);
    wait_timer(16'd9);
    check("R4", "pair1 high before clear", wave_out[1], 1);
    tick();
    check("R4", "pair1 low after clear tick", wave_out[1], 0);
    check("R5", "irq ch3 pulse", match_irq[3], 1);
    wait_timer(16'd20);
    tick(); check("R2", "zero after period match", timer_val, 0);
    tick(); check("R2", "zero held one tick", timer_val, 0);
    tick(); check("R2", "one after rest tick", timer_val, 1);
    wait_timer(16'd20);
    n = 0;
    do begin tick(); n++; end while (timer_val != 16'd20 && n < 100);
    check("R2", "period length p+2", n, 22);
    i0 = 0; i1 = 0; i2 = 0; i3 = 0; w0 = 0; w1 = 0;
    for (int k = 0; k < 22; k++) begin
      tick();
      i0 += match_irq[0]; i1 += match_irq[1]; i2 += match_irq[2]; i3 += match_irq[3];
      w0 += wave_out[0]; w1 += wave_out[1];
    end
    check("R10", "one irq for compare value zero", i0, 1);
    check("R5", "irq ch1 per period", i1, 1);
    check("R5", "irq ch2 per period", i2, 1);
    check("R5", "irq ch3 per period", i3, 1);
    check("R4", "pair0 width n-m", w0, 3);
    check("R4", "pair1 width n-m", w1, 4);
  endtask

  // R1: free-running step, hold and wrap
  task automatic test_free();
    defaults(); rst_sel = 2'b00;
    apply_reset();
    tick_en = 1'b1;
    wait_timer(16'd100);
    tick_en = 1'b0;
    repeat (3) tick();
    check("R1", "timer held with tick_en low", timer_val, 100);
    tick_en = 1'b1;
    tick();
    check("R1", "timer steps by one", timer_val, 101);
    wait_timer(16'hFFFF);
    tick(); check("R1", "wrap to zero", timer_val, 0);
    tick(); check("R1", "no rest tick on wrap", timer_val, 1);
  endtask

  // R3: channel 0 clears the timer, pair 0 barred
  task automatic test_cmp_reset();
    int n, irq0, lo0, w1;
    defaults(); rst_sel = 2'b01; set_cmp(0, 16'd12); ch_en = 8'h0F; pair_init = 4'b0001;
    apply_reset();
    tick_en = 1'b1;
    wait_timer(16'd12);
    tick(); check("R3", "zero after channel 0 match", timer_val, 0);
    tick(); check("R3", "zero held one tick", timer_val, 0);
    tick(); check("R3", "one after rest tick", timer_val, 1);
    wait_timer(16'd12);
    n = 0; irq0 = 0; lo0 = 0; w1 = 0;
    do begin
      tick(); n++;
      irq0 += (match_irq[1:0] != 0); lo0 += (wave_out[0] == 1'b0); w1 += wave_out[1];
    end while (timer_val != 16'd12 && n < 100);
    check("R3", "period length p+2", n, 14);
    check("R3", "pair0 irqs", irq0, 0);
    check("R3", "pair0 held at initial level", lo0, 0);
    check("R4", "pair1 width in compare-clear mode", w1, 4);
  endtask

  // R6: pair stops unless both enables are set
  task automatic test_enable();
    int irq1, lo1, w1;
    defaults(); ch_en = 8'b0000_0100; pair_init = 4'b0010;
    apply_reset();
    tick_en = 1'b1;
    irq1 = 0; lo1 = 0;
    for (int k = 0; k < 30; k++) begin
      tick();
      irq1 += (match_irq[3:2] != 0); lo1 += (wave_out[1] == 1'b0);
    end
    check("R6", "no irq with one enable", irq1, 0);
    check("R6", "initial level held", lo1, 0);
    ch_en = 8'b0000_1100;
    wait_timer(16'd10);
    w1 = 0;
    for (int k = 0; k < 22; k++) begin tick(); w1 += wave_out[1]; end
    check("R6", "width after both enables", w1, 4);
  endtask

  // R7: inversion
  task automatic test_invert();
    int lo1;
    defaults(); ch_en = 8'h0C; pair_inv = 4'b0010;
    apply_reset();
    tick_en = 1'b1;
    wait_timer(16'd10);
    check("R7", "inverted idle level", wave_out[1], 1);
    lo1 = 0;
    for (int k = 0; k < 22; k++) begin tick(); lo1 += (wave_out[1] == 1'b0); end
    check("R7", "inverted active width", lo1, 4);
  endtask

  // R8: output disable and resume
  task automatic test_oe();
    defaults(); ch_en = 8'h0C; pair_oe = 4'b1101; gpo_val = 4'b0010;
    apply_reset();
    tick_en = 1'b1;
    wait_timer(16'd12);
    check("R8", "gpo high while disabled", wave_out[1], 1);
    gpo_val = 4'b0000; #1;
    check("R8", "gpo low while disabled", wave_out[1], 0);
    wait_timer(16'd7);
    check("R8", "gpo level during set state", wave_out[1], 0);
    pair_oe = 4'b1111; #1;
    check("R8", "resume shows held set state", wave_out[1], 1);
    wait_timer(16'd9);
    tick();
    check("R8", "resumed waveform clears", wave_out[1], 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_period();
    test_cmp_reset();
    test_enable();
    test_invert();
    test_oe();
    test_free();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule